// File: doc/BRIEF.md
# Jitter Attenuator Elastic FIFO

This block is a bit-serial elastic store placed between a jittered write-side bit clock and a cleaned read-side copy of the same clock. Both bit clocks arrive as single-cycle strobes inside one fast system clock. Line data is held as 2-bit words. The usable depth is set in blocks of 16 words, from one block to eight blocks.

The block tracks how many bits are held, which is the write pointer minus the read pointer modulo the programmed depth. When that fill level comes within 4 bits of either end, it asks an external rate controller to move the read clock by a small fractional step. Speed-up means the buffer is nearly full, and slow-down means it is nearly empty. Any change on the centring control input starts a recentring phase. During that phase the block steers the fill level towards half depth and shows a busy flag. The flag clears once the fill level is within one bit of the midpoint.

Reset sets the depth to one block. After reset, and after every change of the depth select, both pointers restart with the read pointer half the depth behind the write pointer. The store is cleared at the same time.

Top module: `ja_elastic_fifo`

## Requirements
- R1: The capacity in bits is (depth_sel + 1) × 32, that is, (depth_sel + 1) blocks of 16 two-bit words. The near-full threshold follows the selected depth.
- R2: Reset, and the cycle after any change of depth_sel, set the fill level to half the capacity with zeroed contents. After either event speed_up, slow_down and centring are all low.
- R3: Bits are read in the order they were written. rd_bit presents the bit taken by a read strobe one cycle after that strobe.
- R4: Outside centring, speed_up is high in the cycle after a cycle whose fill level is at least capacity − 4.
- R5: Outside centring, slow_down is high in the cycle after a cycle whose fill level is at most 4.
- R6: speed_up and slow_down are never high together.
- R7: A change of centre_ctl in either direction sets centring in the next cycle.
- R8: While centring is high, speed_up follows fill > half + 1 and slow_down follows fill < half − 1, each one cycle late. Centring clears one cycle after a cycle in which the fill level is within 1 of half.
- R9: A write strobe and a read strobe in the same cycle leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| depth_sel | input | 3 | Depth in blocks minus one |
| centre_ctl | input | 1 | Centring control; any change starts recentring |
| wr_stb | input | 1 | Write-side bit strobe |
| wr_bit | input | 1 | Bit written on wr_stb |
| rd_stb | input | 1 | Read-side bit strobe |
| rd_bit | output | 1 | Bit taken on the last read strobe |
| speed_up | output | 1 | Request to raise the read rate |
| slow_down | output | 1 | Request to lower the read rate |
| centring | output | 1 | Recentring in progress |

## Verification
The bench keeps the default of eight blocks at most. It runs at depth selects 0, 3 and 7, so it covers the 32-bit, 128-bit and 256-bit capacities, both pointer wraps at each size, and the 252-bit near-full threshold at the largest size. Depth switches in mid-stream bring the restart to half fill within reach. Toggling centre_ctl from fill levels far from the midpoint reaches the steering behaviour and the one-bit exit window.

// File: rtl/ja_elastic_fifo.sv
module ja_elastic_fifo #(
  parameter int MAX_BLOCKS  = 8,
  parameter int BLOCK_WORDS = 16,
  parameter int WORD_BITS   = 2,
  parameter int EDGE_MARGIN = 4,
  parameter int CENTRE_TOL  = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MAX_BLOCKS)-1:0] depth_sel,
  input  logic                          centre_ctl,
  input  logic                          wr_stb,
  input  logic                          wr_bit,
  input  logic                          rd_stb,
  output logic                          rd_bit,
  output logic                          speed_up,
  output logic                          slow_down,
  output logic                          centring
);
  localparam int BLOCK_BITS = BLOCK_WORDS * WORD_BITS;
  localparam int MAX_BITS   = MAX_BLOCKS * BLOCK_BITS;
  localparam int PW         = $clog2(MAX_BITS);
  localparam int FW         = PW + 1;
  localparam int SW         = $clog2(MAX_BLOCKS);

  logic [MAX_BITS-1:0] mem;
  logic [FW-1:0]       wp, rp, fill, dbits, half;
  logic [SW-1:0]       depth_q;
  logic                ctl_q;

  wire chg       = depth_sel != depth_q;
  wire ctl_edge  = centre_ctl != ctl_q;

  assign dbits = FW'((FW'(depth_sel) + FW'(1)) * FW'(BLOCK_BITS));
  assign half  = dbits >> 1;
  assign fill  = (wp >= rp) ? wp - rp : wp + dbits - rp;

  wire [FW-1:0] wp_nx = (wp + FW'(1) == dbits) ? '0 : wp + FW'(1);
  wire [FW-1:0] rp_nx = (rp + FW'(1) == dbits) ? '0 : rp + FW'(1);

  wire near_mid = (fill + FW'(CENTRE_TOL) >= half) && (fill <= half + FW'(CENTRE_TOL));
  wire up_nx = centring ? (fill > half + FW'(CENTRE_TOL)) : (fill + FW'(EDGE_MARGIN) >= dbits);
  wire dn_nx = centring ? (fill + FW'(CENTRE_TOL) < half) : (fill <= FW'(EDGE_MARGIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem       <= '0;
      wp        <= FW'(BLOCK_BITS / 2);
      rp        <= '0;
      depth_q   <= '0;
      ctl_q     <= 1'b0;
      rd_bit    <= 1'b0;
      speed_up  <= 1'b0;
      slow_down <= 1'b0;
      centring  <= 1'b0;
    end else if (chg) begin
      mem       <= '0;
      wp        <= half;
      rp        <= '0;
      depth_q   <= depth_sel;
      ctl_q     <= centre_ctl;
      speed_up  <= 1'b0;
      slow_down <= 1'b0;
      centring  <= 1'b0;
    end else begin
      if (wr_stb) begin
        mem[wp[PW-1:0]] <= wr_bit;
        wp <= wp_nx;
      end
      if (rd_stb) begin
        rd_bit <= mem[rp[PW-1:0]];
        rp <= rp_nx;
      end
      ctl_q     <= centre_ctl;
      speed_up  <= up_nx;
      slow_down <= dn_nx;
      if (ctl_edge)
        centring <= 1'b1;
      else if (centring && near_mid)
        centring <= 1'b0;
    end
  end
endmodule

// File: rtl/ja_elastic_fifo_chk.sv
module ja_elastic_fifo_chk #(
  parameter int FW = 9,
  parameter int EDGE_MARGIN = 4,
  parameter int CENTRE_TOL = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chg,
  input logic          ctl_edge,
  input logic          centring,
  input logic          speed_up,
  input logic          slow_down,
  input logic [FW-1:0] fill,
  input logic [FW-1:0] dbits,
  input logic [FW-1:0] half
);
  // R6
  excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(speed_up && slow_down));
  // R2
  depth_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (!speed_up && !slow_down && !centring));
  // R7
  centre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && ctl_edge) |=> centring);
  // R4
  near_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !centring && (fill + FW'(EDGE_MARGIN) >= dbits)) |=> speed_up);
  // R5
  near_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !centring && (fill <= FW'(EDGE_MARGIN))) |=> slow_down);
  // R8
  centre_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !ctl_edge && centring && (fill + FW'(CENTRE_TOL) >= half)
      && (fill <= half + FW'(CENTRE_TOL))) |=> !centring);
endmodule

bind ja_elastic_fifo ja_elastic_fifo_chk #(.FW(FW), .EDGE_MARGIN(EDGE_MARGIN), .CENTRE_TOL(CENTRE_TOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .chg(chg), .ctl_edge(ctl_edge), .centring(centring),
  .speed_up(speed_up), .slow_down(slow_down), .fill(fill), .dbits(dbits), .half(half));

// File: tb/ja_elastic_fifo_tb.sv
module ja_elastic_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] depth_sel = 0;
  logic centre_ctl = 0, wr_stb = 0, wr_bit = 0, rd_stb = 0;
  logic rd_bit, speed_up, slow_down, centring;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  ja_elastic_fifo u_dut (.clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .centre_ctl(centre_ctl),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_stb(rd_stb), .rd_bit(rd_bit),
    .speed_up(speed_up), .slow_down(slow_down), .centring(centring));

  bit q[$];
  int m_dq = 0;
  bit m_ctl = 0, m_cen = 0;

  function automatic int cap(int d); return (d + 1) * 32; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit w, bit b, bit r, bit ctl, int dsel);
    bit e_up, e_dn, e_cen, e_rd, edge_c, chg;
    int f, h;
    @(negedge clk);
    wr_stb = w; wr_bit = b; rd_stb = r; centre_ctl = ctl; depth_sel = dsel[2:0];
    chg = (dsel != m_dq);
    e_rd = 0;
    if (chg) begin
      e_up = 0; e_dn = 0; e_cen = 0;
      m_dq = dsel; m_ctl = ctl;
      q.delete();
      for (int i = 0; i < cap(dsel) / 2; i++) q.push_back(1'b0);
    end else begin
      f = q.size(); h = cap(m_dq) / 2;
      edge_c = (ctl != m_ctl);
      if (m_cen) begin e_up = f > h + 1; e_dn = f < h - 1; end
      else begin e_up = f >= cap(m_dq) - 4; e_dn = f <= 4; end
      if (edge_c) e_cen = 1;
      else if (m_cen && f >= h - 1 && f <= h + 1) e_cen = 0;
      else e_cen = m_cen;
      if (r) e_rd = q.pop_front();
      if (w) q.push_back(b);
      m_ctl = ctl;
    end
    @(posedge clk); #1;
    chk(speed_up == e_up, chg ? "R2" : (m_cen ? "R8" : "R4"), speed_up, e_up);
    chk(slow_down == e_dn, chg ? "R2" : (m_cen ? "R8" : "R5"), slow_down, e_dn);
    chk(centring == e_cen, chg ? "R2" : (edge_c ? "R7" : "R8"), centring, e_cen);
    chk(!(speed_up && slow_down), "R6", {speed_up, slow_down}, 0);
    if (r && !chg) chk(rd_bit == e_rd, (w ? "R9" : "R3"), rd_bit, e_rd);
    m_cen = e_cen;
  endtask

  task automatic rnd(int n, int dsel);
    for (int i = 0; i < n; i++) begin
      bit w, r, c;
      int f = q.size();
      w = $urandom % 2; r = $urandom % 2;
      if (f >= cap(dsel) - 1) w = 0;
      if (f == 0) r = 0;
      c = (($urandom % 40) == 0) ? ~m_ctl : m_ctl;
      step(w, $urandom % 2, r, c, dsel);
    end
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) q.push_back(1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk(!speed_up && !slow_down && !centring, "R2", {speed_up, slow_down, centring}, 0);
    rst_n = 1;
    // R2: the reset contents read back as zeros at half fill
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);
    // R4: fill the 32-bit buffer to the near-full end
    while (q.size() < 29) step(1, q.size() % 2, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(speed_up == 1, "R4", speed_up, 1);
    // R9: paired strobes keep the request
    step(1, 1, 1, 0, 0);
    chk(speed_up == 1, "R9", speed_up, 1);
    // R5: drain to the near-empty end
    while (q.size() > 3) step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(slow_down == 1, "R5", slow_down, 1);
    // R7/R8: recentre from a high fill level
    while (q.size() < 26) step(1, $urandom % 2, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    chk(centring == 1, "R7", centring, 1);
    step(0, 0, 0, 1, 0);
    chk(speed_up == 1, "R8", speed_up, 1);
    while (q.size() > 17) step(0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk(centring == 0, "R8", centring, 0);
    // R8: recentre from a low fill level
    while (q.size() > 8) step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(slow_down == 1, "R8", slow_down, 1);
    while (m_cen) step(1, 1, 0, 0, 0);
    rnd(600, 0);
    // R1/R2: depth changes
    step(0, 0, 0, m_ctl, 3);
    rnd(800, 3);
    step(0, 0, 0, m_ctl, 7);
    while (m_cen) step(0, 0, 0, m_ctl, 7);
    while (q.size() < 252) step(1, $urandom % 2, 0, m_ctl, 7);
    step(0, 0, 0, m_ctl, 7);
    chk(speed_up == 1, "R1", speed_up, 1);
    step(0, 0, 1, m_ctl, 7);
    step(0, 0, 0, m_ctl, 7);
    chk(speed_up == 0, "R1", speed_up, 0);
    rnd(1200, 7);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule